// File: doc/BRIEF.md
# DMA Channel Interrupt and Message-Write Unit

This unit is the interrupt logic of a single DMA channel. The channel engine reports two kinds of event, a normal stop (transfer done) and an abort. Each event is captured in a sticky status bit. Software reads these bits and clears them by writing ones to a clear register. Each event has a mask bit and two enables in a setup register, one for local signalling and one for remote signalling. The unit drives a level interrupt line for a local processor. For a remote host it issues a message-signalled write request.

A remote message is a single 64-bit address plus a 32-bit data word, sent over a valid/ready request. Stop and abort each have their own programmable target address. Both use one shared data word. Software programs everything through a plain synchronous register write port and a combinational read port. The register offsets are the ones the channel's software interface decodes. Bus transport and the engine that raises the events are outside this unit.

Top module: `dma_irq_msg_unit`

## Requirements
- R1: After reset, the status, setup, address and data registers all read 0, `irq_local` is low and `msg_valid` is low.
- R2: A stop event pulse sets status bit 0, and an abort event pulse sets status bit 2. The status register is at offset 0x84. Each bit stays set until software clears it, whatever the setup register holds.
- R3: Writing to the clear register at offset 0x8C clears status bit 0 when data bit 0 is 1, and clears status bit 2 when data bit 2 is 1. A zero in either bit leaves that status bit unchanged. The clear register reads as 0.
- R4: If an event arrives in the same cycle as a clear write for that bit, the status bit ends up set.
- R5: The setup register is at offset 0x88. Its fields are: bit 0 stop mask, bit 2 abort mask, bit 3 remote stop enable, bit 4 local stop enable, bit 5 remote abort enable, bit 6 local abort enable. All other bits read 0.
- R6: `irq_local` is high exactly while some latched status bit has its local enable set and its mask bit clear. It rises in the cycle after the event is sampled.
- R7: An event sampled while its remote enable is set and its mask bit is clear produces one message write. An event sampled with the remote enable clear, or with the mask set, produces none.
- R8: A stop message carries the stop address. Its low half is at 0x90 and its high half at 0x94. An abort message carries the abort address, with its low half at 0xA0 and its high half at 0xA4. Both carry the data word at 0xA8. `msg_valid` rises two cycles after the event is sampled.
- R9: While `msg_valid` is high and `msg_ready` is low, `msg_valid`, `msg_addr` and `msg_data` hold steady. When both kinds of message are pending, the stop message is sent first.
- R10: The address and data registers read back what was written. Unmapped offsets read 0.
- R11: Repeated events of one kind that arrive while an earlier message of that kind waits to be presented merge into one further message. After the last handshake, `msg_valid` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_stop | input | 1 | Stop (done) event pulse from the channel engine |
| ev_abort | input | 1 | Abort event pulse from the channel engine |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_local | output | 1 | Local level interrupt |
| msg_valid | output | 1 | Message write request valid |
| msg_ready | input | 1 | Message write request accepted |
| msg_addr | output | 64 | Message write target address |
| msg_data | output | 32 | Message write data word |

## Verification
Each internal fault shows up at the ports in its own way:
- A lost or stuck status bit shows in the status read the cycle after the event. It also shows on `irq_local` in that same cycle.
- A pending flag that is never set leaves `msg_valid` low when it should rise two cycles after the event. A pending flag that is never cleared leaves `msg_valid` high after the final handshake. Either is visible within three cycles.
- A wrong priority or selection puts the wrong address on `msg_addr` in the first presented cycle.
- An output stage that reloads during backpressure changes `msg_addr` while `msg_ready` is still low.

// File: rtl/dma_irq_msg_unit.sv
module dma_irq_msg_unit #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_stop,
  input  logic              ev_abort,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_local,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [63:0]       msg_addr,
  output logic [31:0]       msg_data
);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'('h84);
  localparam logic [ADDR_W-1:0] OFS_SETUP = ADDR_W'('h88);
  localparam logic [ADDR_W-1:0] OFS_CLR   = ADDR_W'('h8C);
  localparam logic [ADDR_W-1:0] OFS_SA_LO = ADDR_W'('h90);
  localparam logic [ADDR_W-1:0] OFS_SA_HI = ADDR_W'('h94);
  localparam logic [ADDR_W-1:0] OFS_AA_LO = ADDR_W'('hA0);
  localparam logic [ADDR_W-1:0] OFS_AA_HI = ADDR_W'('hA4);
  localparam logic [ADDR_W-1:0] OFS_DATA  = ADDR_W'('hA8);
  localparam int BIT_STOP = 0, BIT_ABORT = 2;
  localparam int EN_RSTOP = 3, EN_LSTOP = 4, EN_RABORT = 5, EN_LABORT = 6;
  localparam logic [6:0] SETUP_KEEP = 7'b1111101;

  logic        stat_stop, stat_abort;
  logic [6:0]  setup_q;
  logic [63:0] stop_adr, abort_adr;
  logic [31:0] data_q;
  logic        pend_stop, pend_abort;
  logic        out_valid;
  logic [63:0] out_adr;
  logic [31:0] out_data;

  wire wr_clr   = reg_we && reg_addr == OFS_CLR;
  wire go_stop  = ev_stop  && setup_q[EN_RSTOP]  && !setup_q[BIT_STOP];
  wire go_abort = ev_abort && setup_q[EN_RABORT] && !setup_q[BIT_ABORT];
  wire load     = (pend_stop || pend_abort) && (!out_valid || msg_ready);
  wire pick_stop = pend_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_stop  <= 1'b0;
      stat_abort <= 1'b0;
      pend_stop  <= 1'b0;
      pend_abort <= 1'b0;
    end else begin
      stat_stop  <= ev_stop  || (stat_stop  && !(wr_clr && reg_wdata[BIT_STOP]));
      stat_abort <= ev_abort || (stat_abort && !(wr_clr && reg_wdata[BIT_ABORT]));
      pend_stop  <= go_stop  || (pend_stop  && !(load && pick_stop));
      pend_abort <= go_abort || (pend_abort && !(load && !pick_stop));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q   <= '0;
      stop_adr  <= '0;
      abort_adr <= '0;
      data_q    <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_SETUP: setup_q          <= reg_wdata[6:0] & SETUP_KEEP;
        OFS_SA_LO: stop_adr[31:0]   <= reg_wdata;
        OFS_SA_HI: stop_adr[63:32]  <= reg_wdata;
        OFS_AA_LO: abort_adr[31:0]  <= reg_wdata;
        OFS_AA_HI: abort_adr[63:32] <= reg_wdata;
        OFS_DATA:  data_q           <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_adr   <= '0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_adr   <= pick_stop ? stop_adr : abort_adr;
      out_data  <= data_q;
    end else if (msg_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_STAT:  reg_rdata = {29'd0, stat_abort, 1'b0, stat_stop};
      OFS_SETUP: reg_rdata = {25'd0, setup_q};
      OFS_SA_LO: reg_rdata = stop_adr[31:0];
      OFS_SA_HI: reg_rdata = stop_adr[63:32];
      OFS_AA_LO: reg_rdata = abort_adr[31:0];
      OFS_AA_HI: reg_rdata = abort_adr[63:32];
      OFS_DATA:  reg_rdata = data_q;
      default:   reg_rdata = '0;
    endcase
  end

  assign irq_local = (stat_stop  && setup_q[EN_LSTOP]  && !setup_q[BIT_STOP]) ||
                     (stat_abort && setup_q[EN_LABORT] && !setup_q[BIT_ABORT]);
  assign msg_valid = out_valid;
  assign msg_addr  = out_adr;
  assign msg_data  = out_data;

  AST_STOP_LATCH:  assert property (@(posedge clk) disable iff (!rst_n) ev_stop |=> stat_stop);   // R2
  AST_ABORT_LATCH: assert property (@(posedge clk) disable iff (!rst_n) ev_abort |=> stat_abort); // R2
  AST_CLR_STOP:    assert property (@(posedge clk) disable iff (!rst_n)
                     (wr_clr && reg_wdata[BIT_STOP] && !ev_stop) |=> !stat_stop);              // R3
  AST_IRQ_QUIET:   assert property (@(posedge clk) disable iff (!rst_n)
                     (!stat_stop && !stat_abort) |-> !irq_local);                              // R6
  AST_MSG_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
                     (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data))); // R9
endmodule

// File: tb/tb_dma_irq_msg_unit.sv
module tb_dma_irq_msg_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_stop = 1'b0, ev_abort = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_local, msg_valid;
  logic        msg_ready = 1'b0;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_irq_msg_unit #(.ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .ev_stop(ev_stop), .ev_abort(ev_abort),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_local(irq_local), .msg_valid(msg_valid), .msg_ready(msg_ready),
    .msg_addr(msg_addr), .msg_data(msg_data));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic s, input logic ab);
    @(negedge clk); ev_stop = s; ev_abort = ab;
    @(negedge clk); ev_stop = 1'b0; ev_abort = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h84, d); chk("R1 status", d, 0);
    rd(8'h88, d); chk("R1 setup", d, 0);
    rd(8'h90, d); chk("R1 stop addr", d, 0);
    rd(8'hA8, d); chk("R1 data", d, 0);
    chk("R1 irq", irq_local, 0);
    chk("R1 valid", msg_valid, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(8'h88, 32'hFFFF_FFFF); rd(8'h88, d); chk("R5 setup bits", d, 32'h7D);
    wr(8'h88, 0);
    wr(8'h90, 32'h1111_2222); wr(8'h94, 32'hAAAA_BBBB);
    wr(8'hA0, 32'h3333_4444); wr(8'hA4, 32'hCCCC_DDDD);
    wr(8'hA8, 32'hC0DE_0001);
    rd(8'h94, d); chk("R10 stop hi", d, 32'hAAAA_BBBB);
    rd(8'hA0, d); chk("R10 abort lo", d, 32'h3333_4444);
    rd(8'hA8, d); chk("R10 data", d, 32'hC0DE_0001);
    rd(8'h98, d); chk("R10 unmapped", d, 0);
    rd(8'h8C, d); chk("R3 clear reads 0", d, 0);
  endtask

  task automatic t_latch_clear;
    logic [31:0] d;
    pulse(1, 0); rd(8'h84, d); chk("R2 stop latched", d, 32'h1);
    pulse(0, 1); rd(8'h84, d); chk("R2 both latched", d, 32'h5);
    chk("R7 no msg when remote off", msg_valid, 0);
    wr(8'h8C, 32'h0); rd(8'h84, d); chk("R3 zero write keeps", d, 32'h5);
    wr(8'h8C, 32'h4); rd(8'h84, d); chk("R3 clear abort only", d, 32'h1);
    @(negedge clk); ev_stop = 1'b1; reg_we = 1'b1; reg_addr = 8'h8C; reg_wdata = 32'h1;
    @(negedge clk); ev_stop = 1'b0; reg_we = 1'b0;
    rd(8'h84, d); chk("R4 set wins", d, 32'h1);
    wr(8'h8C, 32'h5); rd(8'h84, d); chk("R3 clear stop", d, 0);
  endtask

  task automatic t_local_irq;
    wr(8'h88, 32'h10);
    pulse(1, 0); chk("R6 local stop irq", irq_local, 1);
    wr(8'h88, 32'h11); chk("R6 stop masked", irq_local, 0);
    wr(8'h8C, 32'h1);
    wr(8'h88, 32'h40);
    pulse(0, 1); chk("R6 local abort irq", irq_local, 1);
    wr(8'h88, 32'h44); chk("R6 abort masked", irq_local, 0);
    wr(8'h8C, 32'h4); wr(8'h88, 32'h40); chk("R6 cleared irq low", irq_local, 0);
  endtask

  task automatic t_masked_remote;
    wr(8'h88, 32'h19);
    pulse(1, 0);
    repeat (3) @(negedge clk);
    chk("R7 masked no msg", msg_valid, 0);
    chk("R6 masked irq", irq_local, 0);
    wr(8'h8C, 32'h5);
  endtask

  task automatic t_remote_stop;
    wr(8'h88, 32'h08);
    pulse(1, 0); chk("R8 not yet valid", msg_valid, 0);
    @(negedge clk);
    chk("R7 stop msg valid", msg_valid, 1);
    chk("R8 stop addr", msg_addr, 64'hAAAA_BBBB_1111_2222);
    chk("R8 data", msg_data, 32'hC0DE_0001);
    repeat (2) @(negedge clk);
    chk("R9 hold valid", msg_valid, 1);
    chk("R9 hold addr", msg_addr, 64'hAAAA_BBBB_1111_2222);
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    chk("R7 single msg", msg_valid, 0);
    repeat (2) @(negedge clk);
    chk("R7 stays idle", msg_valid, 0);
    wr(8'h8C, 32'h5);
  endtask

  task automatic t_both;
    wr(8'h88, 32'h28);
    pulse(1, 1); @(negedge clk);
    chk("R9 stop first", msg_addr, 64'hAAAA_BBBB_1111_2222);
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    chk("R9 abort next valid", msg_valid, 1);
    chk("R8 abort addr", msg_addr, 64'hCCCC_DDDD_3333_4444);
    @(negedge clk);
    chk("R9 abort held", msg_addr, 64'hCCCC_DDDD_3333_4444);
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    chk("R11 done after both", msg_valid, 0);
    wr(8'h8C, 32'h5);
  endtask

  task automatic t_merge;
    wr(8'h88, 32'h08);
    pulse(1, 0); @(negedge clk);
    chk("R7 first msg", msg_valid, 1);
    pulse(1, 0); pulse(1, 0);
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    chk("R11 merged second msg", msg_valid, 1);
    msg_ready = 1'b1; @(negedge clk); msg_ready = 1'b0;
    chk("R11 no third msg", msg_valid, 0);
    repeat (2) @(negedge clk);
    chk("R11 idle after merge", msg_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_latch_clear;
    t_local_irq;
    t_masked_remote;
    t_remote_stop;
    t_both;
    t_merge;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule